// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches a set of external input pins and turns activity on them into interrupt requests. The pins are split into banks of eight. Each pin has a three-bit trigger code, a mask bit and a pending bit, and these are held in three registers per bank. Pins go through a synchroniser before detection. Depending on its trigger code, a pin sets its pending bit on a level or on an edge. The pending bit stays set until software clears it by writing a one to it.

The lower banks have one interrupt line per pin. All pins of the upper banks are ORed onto one shared line. For each bank, a read-only register returns the pending bits that are not masked. Software reads this register to find which upper pin raised the shared line. Access goes through a simple single-cycle register bus. Read data is registered.

Top module: `eint_ctrl`

## Requirements
- R1: While reset is held and right after it is released, every trigger field reads 0, every mask reads 0xFF (all pins masked), and every interrupt output is low.
- R2: A pin change is seen through two synchroniser flops. A change made between two clock edges moves a pending bit, and the matching output, on the third rising edge after the change, not before.
- R3: The trigger code of pin k in a bank occupies configuration bits [4k+2:4k]. Bit 4k+3 reads 0. The codes are: 0 level low, 1 level high, 2 falling edge, 3 rising edge, 4 both edges. Codes 5, 6 and 7 never set pending.
- R4: An edge code sets pending once per matching edge. A cleared pending bit stays clear while the pin holds still.
- R5: A level code sets pending in every cycle that the level is present. A clear written while the level holds leaves the bit set.
- R6: A mask bit of 1 keeps the pin's output low but does not stop its pending bit from setting. Only mask bits [7:0] are stored, and bits above read 0.
- R7: Writing a 1 to a pending bit clears it. Writing a 0 leaves it unchanged.
- R8: Pin n of banks 0 and 1 drives irq_direct[n], which is high when that pin is pending and unmasked.
- R9: irq_shared is high while any pin of banks 2 and 3 is pending and unmasked.
- R10: Register select 3 of a bank reads pending AND NOT mask for that bank in bits [7:0]. Writes to it change nothing.
- R11: bus_addr[3:2] selects the bank and bus_addr[1:0] selects the register: 0 configuration, 1 mask, 2 pending, 3 active view. Read data appears on the edge that samples the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 32 | Asynchronous external pins |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Bank and register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_direct | output | 16 | Per-pin interrupts for pins 0 to 15 |
| irq_shared | output | 1 | Combined interrupt for pins 16 to 31 |

## Verification
A corrupted trigger field shows up as a pending bit that rises at the wrong point in a pin waveform. It also shows up in the configuration readback on the next read. A stuck or lost pending bit shows on irq_direct or irq_shared within one cycle, because the outputs are combinational from the pending and mask state. A wrong synchroniser depth moves the output edge by a cycle relative to the pin change, and the bench samples exactly at the expected edge. Mask corruption either hides an output or exposes one that should stay low, and the active-view read catches both.

// File: rtl/eint_pkg.sv
package eint_pkg;

   localparam int TRIG_W = 3;

   typedef enum logic [TRIG_W-1:0] {
      TRIG_LVL_LO = 3'd0,
      TRIG_LVL_HI = 3'd1,
      TRIG_FALL   = 3'd2,
      TRIG_RISE   = 3'd3,
      TRIG_BOTH   = 3'd4
   } trig_e;

   localparam logic [1:0] SEL_CFG  = 2'd0;
   localparam logic [1:0] SEL_MASK = 2'd1;
   localparam logic [1:0] SEL_PEND = 2'd2;
   localparam logic [1:0] SEL_ACT  = 2'd3;

   // Detection from the current and previous synchronised sample.
   function automatic logic trig_hit(logic [TRIG_W-1:0] code, logic cur, logic prv);
      logic hit;
      case (code)
         TRIG_LVL_LO: hit = ~cur;
         TRIG_LVL_HI: hit = cur;
         TRIG_FALL:   hit = prv & ~cur;
         TRIG_RISE:   hit = ~prv & cur;
         TRIG_BOTH:   hit = prv ^ cur;
         default:     hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] prv
);

   if (STAGES < 2) begin : g_bad_stages
      $error("eint_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;
   logic [WIDTH-1:0]             last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain  <= '0;
         last_q <= '0;
      end else begin
         chain[0] <= din;
         for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
         last_q <= chain[STAGES-1];
      end
   end

   assign cur = chain[STAGES-1];
   assign prv = last_q;

endmodule

// File: rtl/eint_bank.sv
module eint_bank
   import eint_pkg::*;
#(
   parameter int PINS   = 8,
   parameter int STRIDE = 4,
   parameter int DW     = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [PINS-1:0]            cur,
   input  logic [PINS-1:0]            prv,
   input  logic                       wr_cfg,
   input  logic                       wr_mask,
   input  logic                       wr_clr,
   input  logic [DW-1:0]              wdata,
   output logic [DW-1:0]              cfg_word,
   output logic [PINS-1:0]            mask_q,
   output logic [PINS-1:0]            pend_q,
   output logic [PINS-1:0][TRIG_W-1:0] trig_q
);

   if (STRIDE < TRIG_W) begin : g_bad_stride
      $error("eint_bank: STRIDE narrower than trigger field");
   end
   if (PINS * STRIDE > DW) begin : g_bad_width
      $error("eint_bank: configuration fields exceed data width");
   end
   if (PINS > DW) begin : g_bad_pins
      $error("eint_bank: more pins than data bits");
   end

   logic [PINS-1:0] hit;
   logic [PINS-1:0] clr;

   always_comb begin
      for (int p = 0; p < PINS; p++) begin
         hit[p] = trig_hit(trig_q[p], cur[p], prv[p]);
      end
      clr = wr_clr ? wdata[PINS-1:0] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_q <= '0;
         mask_q <= '1;
         pend_q <= '0;
      end else begin
         if (wr_cfg) begin
            for (int p = 0; p < PINS; p++) begin
               trig_q[p] <= wdata[p*STRIDE +: TRIG_W];
            end
         end
         if (wr_mask) begin
            mask_q <= wdata[PINS-1:0];
         end
         // A detection in the same cycle wins over a clear.
         pend_q <= hit | (pend_q & ~clr);
      end
   end

   always_comb begin
      cfg_word = '0;
      for (int p = 0; p < PINS; p++) begin
         cfg_word[p*STRIDE +: TRIG_W] = trig_q[p];
      end
   end

endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
   import eint_pkg::*;
#(
   parameter int NUM_BANKS    = 4,
   parameter int BANK_PINS    = 8,
   parameter int FIELD_STRIDE = 4,
   parameter int DATA_W       = 32,
   parameter int DIRECT_BANKS = 2,
   parameter int SYNC_STAGES  = 2,
   localparam int NUM_PINS    = NUM_BANKS * BANK_PINS,
   localparam int DIRECT_PINS = DIRECT_BANKS * BANK_PINS,
   localparam int BANK_AW     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int ADDR_W      = BANK_AW + 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_PINS-1:0]    pin_in,
   input  logic                   bus_en,
   input  logic                   bus_we,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [DATA_W-1:0]      bus_wdata,
   output logic [DATA_W-1:0]      bus_rdata,
   output logic [DIRECT_PINS-1:0] irq_direct,
   output logic                   irq_shared
);

   if (DIRECT_BANKS < 1 || DIRECT_BANKS > NUM_BANKS) begin : g_bad_direct
      $error("eint_ctrl: DIRECT_BANKS out of range");
   end
   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("eint_ctrl: at least two banks required");
   end

   logic [NUM_PINS-1:0]                 cur;
   logic [NUM_PINS-1:0]                 prv;
   logic [NUM_PINS-1:0]                 mask_all;
   logic [NUM_PINS-1:0]                 pend_all;
   logic [NUM_PINS-1:0]                 active;
   logic [NUM_PINS-1:0][TRIG_W-1:0]     trig_all;
   logic [NUM_BANKS-1:0][DATA_W-1:0]    cfg_words;
   logic [BANK_AW-1:0]                  bank_sel;
   logic [1:0]                          reg_sel;
   logic [DATA_W-1:0]                   rd_mux;

   assign bank_sel = bus_addr[ADDR_W-1:2];
   assign reg_sel  = bus_addr[1:0];

   eint_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_in),
      .cur   (cur),
      .prv   (prv)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit_bank;
      logic wr_cfg;
      logic wr_mask;
      logic wr_clr;

      assign hit_bank = bus_en && bus_we && (int'(bank_sel) == b);
      assign wr_cfg   = hit_bank && (reg_sel == SEL_CFG);
      assign wr_mask  = hit_bank && (reg_sel == SEL_MASK);
      assign wr_clr   = hit_bank && (reg_sel == SEL_PEND);

      eint_bank #(
         .PINS   (BANK_PINS),
         .STRIDE (FIELD_STRIDE),
         .DW     (DATA_W)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .cur      (cur[b*BANK_PINS +: BANK_PINS]),
         .prv      (prv[b*BANK_PINS +: BANK_PINS]),
         .wr_cfg   (wr_cfg),
         .wr_mask  (wr_mask),
         .wr_clr   (wr_clr),
         .wdata    (bus_wdata),
         .cfg_word (cfg_words[b]),
         .mask_q   (mask_all[b*BANK_PINS +: BANK_PINS]),
         .pend_q   (pend_all[b*BANK_PINS +: BANK_PINS]),
         .trig_q   (trig_all[b*BANK_PINS +: BANK_PINS])
      );
   end

   assign active     = pend_all & ~mask_all;
   assign irq_direct = active[DIRECT_PINS-1:0];

   if (DIRECT_BANKS < NUM_BANKS) begin : g_shared
      assign irq_shared = |active[NUM_PINS-1:DIRECT_PINS];
   end else begin : g_no_shared
      assign irq_shared = 1'b0;
   end

   always_comb begin
      int lo;
      lo     = int'(bank_sel) * BANK_PINS;
      rd_mux = '0;
      if (int'(bank_sel) < NUM_BANKS) begin
         case (reg_sel)
            SEL_CFG:  rd_mux = cfg_words[bank_sel];
            SEL_MASK: rd_mux[BANK_PINS-1:0] = mask_all[lo +: BANK_PINS];
            SEL_PEND: rd_mux[BANK_PINS-1:0] = pend_all[lo +: BANK_PINS];
            default:  rd_mux[BANK_PINS-1:0] = active[lo +: BANK_PINS];
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_en && !bus_we) begin
         bus_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/eint_ctrl_chk.sv
module eint_ctrl_chk
   import eint_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_PINS = 8,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   localparam int NUM_PINS = NUM_BANKS * BANK_PINS
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           bus_en,
   input logic                           bus_we,
   input logic [ADDR_W-1:0]              bus_addr,
   input logic [DATA_W-1:0]              bus_wdata,
   input logic [DATA_W-1:0]              bus_rdata,
   input logic [NUM_PINS-1:0]            cur,
   input logic [NUM_PINS-1:0]            prv,
   input logic [NUM_PINS-1:0]            mask_all,
   input logic [NUM_PINS-1:0]            pend_all,
   input logic [NUM_PINS-1:0][TRIG_W-1:0] trig_all
);

   // R1: the first cycle out of reset shows the reset state.
   p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (mask_all == '1 && pend_all == '0));

   // R11: read data holds while there is no access.
   p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_en |=> $stable(bus_rdata));

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      localparam int B = i / BANK_PINS;
      localparam int K = i % BANK_PINS;

      // R7: a pending bit drops only after a clear write with a 1 in its position.
      p_clear_only_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pend_all[i]) |->
            $past(bus_en && bus_we && int'(bus_addr[ADDR_W-1:2]) == B &&
                  bus_addr[1:0] == SEL_PEND && bus_wdata[K]));

      // R5: a present level sets pending on the next edge.
      p_level_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
         ((trig_all[i] == TRIG_LVL_HI && cur[i]) ||
          (trig_all[i] == TRIG_LVL_LO && !cur[i])) |=> pend_all[i]);

      // R4: a rising sample pair sets pending under the rising code.
      p_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_all[i] == TRIG_RISE && cur[i] && !prv[i]) |=> pend_all[i]);

      // R3: codes 5 to 7 never raise pending.
      p_idle_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_all[i] > TRIG_BOTH) |=> !$rose(pend_all[i]));
   end

endmodule

bind eint_ctrl eint_ctrl_chk #(
   .NUM_BANKS (NUM_BANKS),
   .BANK_PINS (BANK_PINS),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_en    (bus_en),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .cur       (cur),
   .prv       (prv),
   .mask_all  (mask_all),
   .pend_all  (pend_all),
   .trig_all  (trig_all)
);

// File: tb/sim_eint_ctrl.sv
module sim_eint_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pins = '0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] irq_direct;
   logic        irq_shared;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic rd_due = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   eint_ctrl u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_in     (pins),
      .bus_en     (bus_en),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .irq_direct (irq_direct),
      .irq_shared (irq_shared)
   );

   task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_wr(int bank, int sel, logic [31:0] d);
      bus_en    = 1'b1;
      bus_we    = 1'b1;
      bus_addr  = 4'(bank * 4 + sel);
      bus_wdata = d;
      tick();
      bus_en = 1'b0;
      bus_we = 1'b0;
   endtask

   // Driver: pushes the expected item, then issues the read.
   task automatic bus_rd(int bank, int sel, logic [31:0] exp, string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      bus_en   = 1'b1;
      bus_we   = 1'b0;
      bus_addr = 4'(bank * 4 + sel);
      tick();
      bus_en = 1'b0;
   endtask

   // Monitor: compares each read result as it appears.
   always @(posedge clk) rd_due <= bus_en && !bus_we && rst_n;

   always @(negedge clk) begin
      if (rd_due) begin
         if (exp_q.size() == 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R11: unexpected read result actual %h expected none", bus_rdata);
         end else begin
            check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      tick(3);
      check({15'd0, irq_shared, irq_direct}, 32'h0, "R1 outputs in reset");
      rst_n = 1'b1;
      tick(3);
      check({15'd0, irq_shared, irq_direct}, 32'h0, "R1 outputs after reset");
      for (int b = 0; b < 4; b++) begin
         bus_rd(b, 0, 32'h0, "R1 cfg reset R11");
         bus_rd(b, 1, 32'hFF, "R1 mask reset");
      end
      // Pins low with level-low code: pending set but masked.
      bus_rd(0, 2, 32'hFF, "R5 level low pending");
      bus_rd(0, 3, 32'h0, "R10 R6 active masked");

      // Disable all pins, clear pending.
      for (int b = 0; b < 4; b++) bus_wr(b, 0, 32'h5555_5555);
      for (int b = 0; b < 4; b++) bus_wr(b, 2, 32'hFF);
      bus_rd(2, 2, 32'h0, "R7 R3 cleared with idle code");
      bus_rd(1, 0, 32'h5555_5555, "R3 cfg readback");
      bus_wr(3, 0, 32'hFFFF_FFFF);
      bus_rd(3, 0, 32'h7777_7777, "R3 field width");
      pins = '1;
      tick(5);
      pins = '0;
      tick(5);
      bus_rd(3, 2, 32'h0, "R3 code 7 idle");
      bus_rd(1, 2, 32'h0, "R3 code 5 idle");
      bus_wr(3, 0, 32'h5555_5555);

      // Rising edge on pin 3, latency.
      bus_wr(0, 0, 32'h5555_3555);
      bus_wr(0, 1, 32'hF7);
      pins[3] = 1'b1;
      tick(2);
      check({16'd0, irq_direct}, 32'h0, "R2 not before third edge");
      tick();
      check({16'd0, irq_direct}, 32'h8, "R2 R8 rising sets");
      bus_wr(0, 2, 32'h08);
      check({16'd0, irq_direct}, 32'h0, "R7 clear");
      tick(5);
      check({16'd0, irq_direct}, 32'h0, "R4 once per edge");

      // Write of zero leaves pending.
      pins[3] = 1'b0;
      tick(4);
      pins[3] = 1'b1;
      tick(4);
      bus_wr(0, 2, 32'hF7);
      bus_rd(0, 2, 32'h08, "R7 zero write no effect");
      bus_wr(0, 2, 32'h08);
      bus_rd(0, 2, 32'h0, "R7 one clears");

      // Falling edge.
      bus_wr(0, 0, 32'h5555_2555);
      pins[3] = 1'b0;
      tick(4);
      check({16'd0, irq_direct}, 32'h8, "R3 falling code");
      bus_wr(0, 2, 32'h08);

      // Both edges.
      bus_wr(0, 0, 32'h5555_4555);
      pins[3] = 1'b1;
      tick(4);
      check({16'd0, irq_direct}, 32'h8, "R3 both rise");
      bus_wr(0, 2, 32'h08);
      tick();
      check({16'd0, irq_direct}, 32'h0, "R4 both cleared");
      pins[3] = 1'b0;
      tick(4);
      check({16'd0, irq_direct}, 32'h8, "R3 both fall");
      bus_wr(0, 2, 32'h08);

      // Level high survives a clear.
      bus_wr(0, 0, 32'h5555_1555);
      pins[3] = 1'b1;
      tick(4);
      bus_wr(0, 2, 32'h08);
      check({16'd0, irq_direct}, 32'h8, "R5 level resets after clear");
      pins[3] = 1'b0;
      tick(4);
      bus_wr(0, 2, 32'h08);
      check({16'd0, irq_direct}, 32'h0, "R5 level gone then cleared");

      // Mask blocks output, not pending.
      bus_wr(0, 1, 32'hFF);
      pins[3] = 1'b1;
      tick(4);
      check({16'd0, irq_direct}, 32'h0, "R6 masked output low");
      bus_rd(0, 2, 32'h08, "R6 pending records while masked");
      bus_rd(0, 3, 32'h0, "R10 active hides masked");
      bus_wr(0, 1, 32'hF7);
      check({16'd0, irq_direct}, 32'h8, "R6 unmask exposes");
      pins[3] = 1'b0;
      tick(4);
      bus_wr(0, 2, 32'h08);
      bus_wr(2, 1, 32'hFFFF_FF00);
      bus_rd(2, 1, 32'h0, "R6 mask upper bits dropped");
      bus_wr(2, 1, 32'hFF);

      // Direct line of bank 1.
      bus_wr(1, 0, 32'h5553_5555);
      bus_wr(1, 1, 32'hEF);
      pins[12] = 1'b1;
      tick(4);
      check({16'd0, irq_direct}, 32'h1000, "R8 pin 12 own line");
      check({31'd0, irq_shared}, 32'h0, "R9 shared idle");
      bus_wr(1, 2, 32'h10);

      // Shared line from banks 2 and 3.
      bus_wr(2, 0, 32'h5555_5155);
      bus_wr(3, 0, 32'h5515_5555);
      bus_wr(2, 1, 32'hFB);
      bus_wr(3, 1, 32'hDF);
      pins[18] = 1'b1;
      pins[29] = 1'b1;
      tick(4);
      check({31'd0, irq_shared}, 32'h1, "R9 shared raised");
      check({16'd0, irq_direct}, 32'h0, "R9 upper pins not direct");
      bus_rd(2, 3, 32'h04, "R10 active bank 2");
      bus_rd(3, 3, 32'h20, "R10 active bank 3");
      pins[18] = 1'b0;
      tick(4);
      bus_wr(2, 2, 32'h04);
      tick(2);
      check({31'd0, irq_shared}, 32'h1, "R9 shared held by other pin");
      pins[29] = 1'b0;
      tick(4);
      bus_wr(3, 2, 32'h20);
      tick(2);
      check({31'd0, irq_shared}, 32'h0, "R9 shared released");

      // Active view ignores writes; read data holds.
      bus_wr(3, 3, 32'hFF);
      bus_rd(3, 2, 32'h0, "R10 write to active ignored pend");
      bus_rd(3, 1, 32'hDF, "R10 write to active ignored mask");
      tick(3);
      check(bus_rdata, 32'hDF, "R11 read data holds");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule